// File: doc/BRIEF.md
# Deferred Soft Reset Sequencer

This block lets software reset the configuration side of a network MAC without risking a hung configuration bus. Software requests the reset by writing a one to bit 0 of a control register. The request is held until the transmit and receive DMA engines both report idle. Only then does the block drive a synchronous reset pulse of fixed length to the rest of the MAC, which returns every MAC register to its default value.

Software polls the same bit to learn when the reset has finished. The bit reads one while the reset is waiting or running, and zero once the reset is over. After that, software must program the MAC again.

The block also holds the latched host error condition. It keeps the error code readable until the reset pulse, so software can find out what went wrong before it requests a recovery reset. The pulse then clears the error. Software must make sure that no frames are still in flight before it makes a request.

Top module: `srst_ctrl`

## Requirements
- R1: A write to address 0 with data bit 0 set, while no request is pending, makes bit 0 of a read at address 0 return one from the following cycle. All other bits at address 0 read zero.
- R2: While a request is pending and `tx_idle` or `rx_idle` is low, `mac_srst` stays low.
- R3: `mac_srst` rises in the cycle after the first clock edge at which a request is pending and both idle inputs are high. It then stays high for exactly PULSE_LEN cycles (default 4).
- R4: Bit 0 at address 0 reads zero in the first cycle after the pulse ends. `mac_srst` is never high while that bit reads zero.
- R5: A write with data bit 0 clear has no effect. A further write of one while a request is pending does not start a second pulse. Once the pulse ends, `mac_srst` stays low until a new request is made.
- R6: An `err_evt` pulse while no error is latched raises `host_err_irq`. It also stores `err_code`, and address 1 then reads `{code, 1'b1}`, with the code in bits ERR_W:1 and the flag in bit 0. Later events leave the first code in place.
- R7: The error status at address 1 and `host_err_irq` stay unchanged while a request waits. They read zero from the first cycle after the pulse. Error events that arrive during the pulse are discarded.
- R8: While `rst_n` is low and right after it is released, `mac_srst`, `host_err_irq` and both registers read zero.
- R9: Reads of any address other than 0 and 1 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address (combinational read) |
| rd_data | output | DATA_W | Read data |
| tx_idle | input | 1 | Transmit DMA reports idle |
| rx_idle | input | 1 | Receive DMA reports idle |
| err_evt | input | 1 | Host error event pulse |
| err_code | input | ERR_W | Code of the host error event |
| host_err_irq | output | 1 | Latched host error interrupt |
| mac_srst | output | 1 | Synchronous reset pulse to the MAC |

## Verification
The bench sweeps which DMA engine is busy (none, transmit, receive or both) against wait lengths of zero to five cycles. A design that ignored one idle input would fire the pulse early, and one that acted on the first write would not wait at all. Each pass measures the pulse length and the cycle in which the poll bit clears, so an off-by-one counter or a bit that clears too early or too late gives a mismatch. Each pass also writes one again while the request is pending and watches for a second pulse, which a design that queues requests would produce. Every error code value is latched, overwritten, held through the wait and hit during the pulse. A latch that keeps the newest code, that clears on the request instead of on the pulse, or that lets an error during the pulse survive would read back wrongly.

// File: rtl/srst_pkg.sv
package srst_pkg;

  localparam int unsigned SR_ADDR_CTRL = 0;
  localparam int unsigned SR_ADDR_ERR  = 1;

  typedef enum logic [1:0] {
    SR_IDLE  = 2'd0,
    SR_WAIT  = 2'd1,
    SR_PULSE = 2'd2
  } srst_state_e;

endpackage

// File: rtl/srst_req_fsm.sv
module srst_req_fsm
  import srst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_set,
  input  logic both_idle,
  input  logic pulse_last,
  output logic pending,
  output logic pulse_on
);

  srst_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SR_IDLE:  if (req_set)    state_d = SR_WAIT;
      SR_WAIT:  if (both_idle)  state_d = SR_PULSE;
      SR_PULSE: if (pulse_last) state_d = SR_IDLE;
      default:                  state_d = SR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SR_IDLE;
    else        state_q <= state_d;
  end

  assign pending  = (state_q != SR_IDLE);
  assign pulse_on = (state_q == SR_PULSE);

endmodule

// File: rtl/srst_pulse_cnt.sv
module srst_pulse_cnt #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic last
);

  generate
    if (PULSE_LEN <= 1) begin : g_single
      assign last = active;
    end else begin : g_count
      localparam int unsigned CNT_W = $clog2(PULSE_LEN);
      localparam logic [CNT_W-1:0] LAST_V = CNT_W'(PULSE_LEN - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!active) cnt_q <= '0;
        else if (cnt_q != LAST_V) cnt_q <= cnt_q + 1'b1;
        else             cnt_q <= '0;
      end

      assign last = active && (cnt_q == LAST_V);
    end
  endgenerate

endmodule

// File: rtl/srst_err_latch.sv
module srst_err_latch #(
  parameter int unsigned ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt,
  input  logic [ERR_W-1:0] code,
  output logic             flag,
  output logic [ERR_W-1:0] code_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      code_q <= '0;
    end else if (clr) begin
      flag   <= 1'b0;
      code_q <= '0;
    end else if (evt && !flag) begin
      flag   <= 1'b1;
      code_q <= code;
    end
  end

endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
  import srst_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ERR_W     = 4,
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tx_idle,
  input  logic              rx_idle,
  input  logic              err_evt,
  input  logic [ERR_W-1:0]  err_code,
  output logic              host_err_irq,
  output logic              mac_srst
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(SR_ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_ERR  = ADDR_W'(SR_ADDR_ERR);

  function automatic logic [DATA_W-1:0] ctrl_word(input logic pend);
    ctrl_word = DATA_W'(pend);
  endfunction

  function automatic logic [DATA_W-1:0] err_word(input logic flg,
                                                 input logic [ERR_W-1:0] cd);
    err_word = DATA_W'({cd, flg});
  endfunction

  logic             req_set;
  logic             both_idle;
  logic             pulse_last;
  logic             req_pending;
  logic             pulse_on;
  logic [ERR_W-1:0] err_code_q;
  logic             unused_wr_bits;

  assign req_set        = wr_en && (wr_addr == A_CTRL) && wr_data[0];
  assign both_idle      = tx_idle && rx_idle;
  assign unused_wr_bits = ^wr_data[DATA_W-1:1];

  srst_req_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_set    (req_set),
    .both_idle  (both_idle),
    .pulse_last (pulse_last),
    .pending    (req_pending),
    .pulse_on   (pulse_on)
  );

  srst_pulse_cnt #(.PULSE_LEN(PULSE_LEN)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (pulse_on),
    .last   (pulse_last)
  );

  srst_err_latch #(.ERR_W(ERR_W)) u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (pulse_on),
    .evt    (err_evt),
    .code   (err_code),
    .flag   (host_err_irq),
    .code_q (err_code_q)
  );

  assign mac_srst = pulse_on;

  always_comb begin
    if (rd_addr == A_CTRL)     rd_data = ctrl_word(req_pending);
    else if (rd_addr == A_ERR) rd_data = err_word(host_err_irq, err_code_q);
    else                       rd_data = '0;
  end

endmodule

// File: rtl/srst_ctrl_sva.sv
module srst_ctrl_sva #(
  parameter int unsigned PULSE_LEN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic tx_idle,
  input logic rx_idle,
  input logic err_evt,
  input logic req_set,
  input logic req_pending,
  input logic mac_srst,
  input logic host_err_irq
);

  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= 0;
    else if (mac_srst) run_q <= run_q + 1;
    else               run_q <= 0;
  end

  a_r1_pending_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_pending) |-> $past(req_set));

  a_r2_pulse_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mac_srst) |-> $past(tx_idle && rx_idle && req_pending));

  a_r3_pulse_not_too_long: assert property (@(posedge clk) disable iff (!rst_n)
    mac_srst |-> (run_q < PULSE_LEN));

  a_r3_pulse_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mac_srst) |-> (run_q == PULSE_LEN));

  a_r4_bit_clears_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mac_srst) |-> !req_pending);

  a_r4_no_pulse_without_pending: assert property (@(posedge clk) disable iff (!rst_n)
    mac_srst |-> req_pending);

  a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pending && !mac_srst) |=> req_pending);

  a_r6_irq_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_err_irq) |-> $past(err_evt));

  a_r7_err_cleared_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mac_srst) |-> !host_err_irq);

endmodule

bind srst_ctrl srst_ctrl_sva #(.PULSE_LEN(PULSE_LEN)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_idle      (tx_idle),
  .rx_idle      (rx_idle),
  .err_evt      (err_evt),
  .req_set      (req_set),
  .req_pending  (req_pending),
  .mac_srst     (mac_srst),
  .host_err_irq (host_err_irq)
);

// File: tb/srst_ctrl_bench.sv
module srst_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int EW = 4;
  localparam int PLEN = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          tx_idle = 1'b1;
  logic          rx_idle = 1'b1;
  logic          err_evt = 1'b0;
  logic [EW-1:0] err_code = '0;
  logic          host_err_irq;
  logic          mac_srst;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srst_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ERR_W(EW), .PULSE_LEN(PLEN)) u_srst_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_idle(tx_idle), .rx_idle(rx_idle),
    .err_evt(err_evt), .err_code(err_code), .host_err_irq(host_err_irq),
    .mac_srst(mac_srst)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    rd_addr = AW'(a);
    #1;
    v = rd_data;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  // Expected error register image: code above the flag bit
  function automatic logic [DW-1:0] exp_err(input logic f, input int c);
    return DW'(c * 2 + (f ? 1 : 0));
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) tick();
    // R8: reset state
    check("R8 srst in reset", DW'(mac_srst), 0);
    rst_n = 1'b1;
    tick();
    check("R8 srst after reset", DW'(mac_srst), 0);
    check("R8 irq after reset", DW'(host_err_irq), 0);
    rd(0, v); check("R8 ctrl after reset", v, 0);
    rd(1, v); check("R8 err after reset", v, 0);

    // R9: unmapped addresses
    for (int a = 2; a < (1 << AW); a++) begin
      rd(a, v); check("R9 unmapped read", v, 0);
    end

    // R5: writing zero has no effect
    wr(0, 32'hFFFF_FFFE);
    for (int k = 0; k < 3; k++) begin
      rd(0, v); check("R5 zero write ctrl", v, 0);
      check("R5 zero write srst", DW'(mac_srst), 0);
      tick();
    end

    // R1..R5 sweep: busy engine mask x wait length
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 6; d++) begin
        tx_idle = !m[0]; rx_idle = !m[1];
        if (m == 0 && d > 0) break;
        wr(0, (d % 2) ? 32'hFFFF_FFFF : 32'h1);
        rd(0, v); check("R1 request bit set", v, 1);
        for (int i = 0; i < d; i++) begin
          if (i == 0) wr(0, 32'h1);
          else tick();
          check("R2 held while busy", DW'(mac_srst), 0);
          rd(0, v); check("R5 single pending", v, 1);
        end
        tx_idle = 1'b1; rx_idle = 1'b1;
        tick();
        for (int k = 0; k < PLEN; k++) begin
          check("R3 pulse high", DW'(mac_srst), 1);
          rd(0, v); check("R4 bit during pulse", v, 1);
          tick();
        end
        check("R3 pulse ended", DW'(mac_srst), 0);
        rd(0, v); check("R4 bit cleared", v, 0);
        for (int k = 0; k < 3; k++) begin
          tick();
          check("R5 no second pulse", DW'(mac_srst), 0);
        end
      end
    end

    // R6, R7: error latch across all codes
    for (int c = 0; c < (1 << EW); c++) begin
      err_evt = 1'b1; err_code = EW'(c);
      tick();
      err_evt = 1'b1; err_code = EW'(c ^ 5);
      rd(1, v); check("R6 code latched", v, exp_err(1, c));
      check("R6 irq raised", DW'(host_err_irq), 1);
      tick();
      err_evt = 1'b0;
      rd(1, v); check("R6 first code kept", v, exp_err(1, c));
      tx_idle = 1'b0; rx_idle = 1'(c % 2);
      wr(0, 32'h1);
      tick();
      rd(1, v); check("R7 held while waiting", v, exp_err(1, c));
      check("R7 irq held while waiting", DW'(host_err_irq), 1);
      tx_idle = 1'b1; rx_idle = 1'b1;
      tick();
      check("R3 pulse starts", DW'(mac_srst), 1);
      err_evt = 1'b1; err_code = EW'(c);
      tick();
      err_evt = 1'b0;
      repeat (PLEN - 1) tick();
      check("R4 pulse done", DW'(mac_srst), 0);
      rd(1, v); check("R7 err cleared", v, 0);
      check("R7 irq cleared", DW'(host_err_irq), 0);
      rd(0, v); check("R4 ctrl cleared", v, 0);
    end

    // R8: hardware reset mid-request
    tx_idle = 1'b0;
    err_evt = 1'b1; err_code = 4'h9;
    wr(0, 32'h1);
    err_evt = 1'b0;
    rst_n = 1'b0;
    tick();
    rd(0, v); check("R8 ctrl in reset", v, 0);
    rd(1, v); check("R8 err in reset", v, 0);
    rst_n = 1'b1; tx_idle = 1'b1;
    tick(); tick();
    check("R8 no pulse after reset", DW'(mac_srst), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule